// File: doc/BRIEF.md
# Infrared Pulse-Position Frame Transmitter

This block turns one remote-control command into a carrier-modulated infrared drive signal. When a validated key press is flagged, it builds a 32-bit command word and sends it as a full frame. The word holds a 16-bit address made from switch inputs and two mask registers, the 8-bit data code, and that code's complement. Each bit is sent as a short carrier burst. The length of the silence that follows the burst tells a 0 from a 1.

While the key stays down, frames start on a fixed period. Every frame after the first is a short repeat pattern with no payload. When the key is released, the frame in flight finishes and nothing more is sent. An active-low indicator output is asserted while a frame is being sent.

All timing is counted in slots of `SLOT_CLKS` clocks, and every burst and space is a whole number of slots. With a 455 kHz clock and the default parameters, one slot lasts about 0.55 ms. The carrier is the clock divided by 12, and it is high for 4 of every 12 clocks.

Top module: `irppm_tx`

## Requirements
- R1: During and right after a synchronous reset, `ir_out` is 0 and `led_n` is 1, including a reset taken in the middle of a frame, and no frame follows the reset until a new key press.
- R2: On a `key_valid` pulse while idle, a full frame is sent. It is a 16-slot burst, then an 8-slot space, then 32 bit cells, then one trailing 1-slot burst.
- R3: Each bit cell is one burst slot followed by one space slot for a 0 or three space slots for a 1. The bits are sent in order word[0] to word[31], where word[7:0] is the low address byte, word[15:8] is the high address byte, word[23:16] is `data_code`, and word[31:24] is the complement of `data_code`.
- R4: The low address byte is `addr_sw | mask_lo`.
- R5: Bit i of the high address byte equals low-address bit i where `inv_sw[i] | mask_hi[i]` is 1, and equals its complement where that OR is 0.
- R6: While `key_held` is 1 at the end of a frame period, another frame starts exactly `FRAME_SLOTS` slots after the previous one. Every frame after the first is a 16-slot burst, a 4-slot space and a 1-slot burst.
- R7: If `key_held` is 0 when a frame period ends, the block goes idle and sends nothing more. A release in the middle of a frame does not cut that frame short.
- R8: `led_n` is 0 from the first burst slot of a frame through its last burst slot, and 1 at all other times.
- R9: In every burst slot, `ir_out` is high for exactly `CARR_ON` of each `CARR_DIV` clocks. Outside burst slots, `ir_out` stays 0.
- R10: A `key_valid` pulse while a frame or its period is still running has no effect. No extra frame appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | One-clock pulse: a debounced key press is ready to send |
| key_held | input | 1 | Level: the key is still pressed |
| addr_sw | input | AW | Address switch bits |
| inv_sw | input | AW | Inversion-control switch bits for the high address byte |
| mask_lo | input | AW | Mask ORed into the low address byte |
| mask_hi | input | AW | Mask ORed into the inversion control |
| data_code | input | DW | Command data code |
| ir_out | output | 1 | Carrier-modulated infrared drive, registered |
| led_n | output | 1 | Active-low transmit indicator, registered |

## Verification
A wrong sequencer state appears at `ir_out` within one slot. A burst appears where a space belongs, or the reverse, and the per-slot carrier-count comparison catches it at that slot. A wrong bit value or wrong address formation changes the length of one bit cell, so it shows up both in the decoded word and in the envelope shift that follows it. A wrong frame-period count or a wrong held-key decision only becomes visible at the next frame start, which comes one full period (193 slots) after the previous one. For that reason, the repeat and release scenarios capture four whole periods.

// File: rtl/irppm_pkg.sv
package irppm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_GAP   = 3'd2,
    ST_MARK  = 3'd3,
    ST_SPACE = 3'd4,
    ST_TRAIL = 3'd5,
    ST_WAIT  = 3'd6
  } seq_st_t;
endpackage

// File: rtl/irppm_word.sv
module irppm_word #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic [AW-1:0]        addr_sw,
  input  logic [AW-1:0]        inv_sw,
  input  logic [AW-1:0]        mask_lo,
  input  logic [AW-1:0]        mask_hi,
  input  logic [DW-1:0]        data_code,
  output logic [2*AW+2*DW-1:0] word
);
  logic [AW-1:0] lo_byte;
  logic [AW-1:0] hi_byte;

  assign lo_byte = addr_sw | mask_lo;

  // keep the low bit where the select is set, flip it where it is clear
  for (genvar i = 0; i < AW; i++) begin : g_hi
    always_comb begin
      if (inv_sw[i] | mask_hi[i]) hi_byte[i] = lo_byte[i];
      else                        hi_byte[i] = ~lo_byte[i];
    end
  end

  assign word = {~data_code, data_code, hi_byte, lo_byte};
endmodule

// File: rtl/irppm_carrier.sv
module irppm_carrier #(
  parameter int CARR_DIV = 12,
  parameter int CARR_ON  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic carr_on
);
  localparam int CW = (CARR_DIV > 1) ? $clog2(CARR_DIV) : 1;

  logic [CW-1:0] cc;

  always_ff @(posedge clk) begin
    if (rst || restart)               cc <= '0;
    else if (cc == CW'(CARR_DIV - 1)) cc <= '0;
    else                              cc <= cc + 1'b1;
  end

  assign carr_on = (cc < CW'(CARR_ON));
endmodule

// File: rtl/irppm_seq.sv
module irppm_seq
  import irppm_pkg::*;
#(
  parameter int SLOT_CLKS   = 252,
  parameter int HDR_SLOTS   = 16,
  parameter int GAP_SLOTS   = 8,
  parameter int RPT_SLOTS   = 4,
  parameter int ZERO_SLOTS  = 1,
  parameter int ONE_SLOTS   = 3,
  parameter int FRAME_SLOTS = 193,
  parameter int NBITS       = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            key_valid,
  input  logic                            key_held,
  input  logic [NBITS-1:0]                word,
  output logic                            burst,
  output logic                            active,
  output logic                            restart,
  output seq_st_t                         st,
  output logic [$clog2(SLOT_CLKS)-1:0]    sc,
  output logic [$clog2(FRAME_SLOTS)-1:0]  per
);
  localparam int SCW  = $clog2(SLOT_CLKS);
  localparam int PW   = $clog2(FRAME_SLOTS);
  localparam int SEGW = $clog2(HDR_SLOTS + GAP_SLOTS + RPT_SLOTS + ONE_SLOTS + ZERO_SLOTS + 1);
  localparam int BIW  = $clog2(NBITS);

  logic [SEGW-1:0]  seg;
  logic [BIW-1:0]   bi;
  logic [NBITS-1:0] sh;
  logic             rep;
  logic             tick;

  assign tick    = (st != ST_IDLE) && (sc == SCW'(SLOT_CLKS - 1));
  assign restart = (st == ST_IDLE) || tick;
  assign burst   = (st == ST_HDR) || (st == ST_MARK) || (st == ST_TRAIL);
  assign active  = (st != ST_IDLE) && (st != ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      sc  <= '0;
      per <= '0;
      seg <= '0;
      bi  <= '0;
      sh  <= '0;
      rep <= 1'b0;
    end else if (st == ST_IDLE) begin
      sc  <= '0;
      per <= '0;
      if (key_valid) begin
        st  <= ST_HDR;
        seg <= SEGW'(HDR_SLOTS - 1);
        rep <= 1'b0;
        sh  <= word;
        bi  <= '0;
      end
    end else if (!tick) begin
      sc <= sc + 1'b1;
    end else begin
      sc <= '0;
      if (st == ST_WAIT) begin
        if (per == PW'(FRAME_SLOTS - 1)) begin
          per <= '0;
          if (key_held) begin
            st  <= ST_HDR;
            seg <= SEGW'(HDR_SLOTS - 1);
            rep <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end else begin
          per <= per + 1'b1;
        end
      end else begin
        per <= per + 1'b1;
        if (seg != '0) begin
          seg <= seg - 1'b1;
        end else begin
          case (st)
            ST_HDR: begin
              st  <= ST_GAP;
              seg <= rep ? SEGW'(RPT_SLOTS - 1) : SEGW'(GAP_SLOTS - 1);
            end
            ST_GAP: begin
              st  <= rep ? ST_TRAIL : ST_MARK;
              seg <= '0;
            end
            ST_MARK: begin
              st  <= ST_SPACE;
              seg <= sh[0] ? SEGW'(ONE_SLOTS - 1) : SEGW'(ZERO_SLOTS - 1);
            end
            ST_SPACE: begin
              seg <= '0;
              if (bi == BIW'(NBITS - 1)) begin
                st <= ST_TRAIL;
              end else begin
                st <= ST_MARK;
                bi <= bi + 1'b1;
                sh <= sh >> 1;
              end
            end
            ST_TRAIL: st <= ST_WAIT;
            default:  st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irppm_tx.sv
module irppm_tx
  import irppm_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SLOT_CLKS   = 252,
  parameter int CARR_DIV    = 12,
  parameter int CARR_ON     = 4,
  parameter int HDR_SLOTS   = 16,
  parameter int GAP_SLOTS   = 8,
  parameter int RPT_SLOTS   = 4,
  parameter int ZERO_SLOTS  = 1,
  parameter int ONE_SLOTS   = 3,
  parameter int FRAME_SLOTS = 193
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_valid,
  input  logic          key_held,
  input  logic [AW-1:0] addr_sw,
  input  logic [AW-1:0] inv_sw,
  input  logic [AW-1:0] mask_lo,
  input  logic [AW-1:0] mask_hi,
  input  logic [DW-1:0] data_code,
  output logic          ir_out,
  output logic          led_n
);
  localparam int NBITS = 2 * AW + 2 * DW;
  localparam int SCW   = $clog2(SLOT_CLKS);
  localparam int PW    = $clog2(FRAME_SLOTS);

  logic [NBITS-1:0] word;
  logic             burst;
  logic             active;
  logic             restart;
  logic             carr_on;
  seq_st_t          st_w;
  logic [SCW-1:0]   sc_w;
  logic [PW-1:0]    per_w;

  irppm_word #(.AW(AW), .DW(DW)) u_word (
    .addr_sw   (addr_sw),
    .inv_sw    (inv_sw),
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi),
    .data_code (data_code),
    .word      (word)
  );

  irppm_seq #(
    .SLOT_CLKS   (SLOT_CLKS),
    .HDR_SLOTS   (HDR_SLOTS),
    .GAP_SLOTS   (GAP_SLOTS),
    .RPT_SLOTS   (RPT_SLOTS),
    .ZERO_SLOTS  (ZERO_SLOTS),
    .ONE_SLOTS   (ONE_SLOTS),
    .FRAME_SLOTS (FRAME_SLOTS),
    .NBITS       (NBITS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .key_valid (key_valid),
    .key_held  (key_held),
    .word      (word),
    .burst     (burst),
    .active    (active),
    .restart   (restart),
    .st        (st_w),
    .sc        (sc_w),
    .per       (per_w)
  );

  irppm_carrier #(.CARR_DIV(CARR_DIV), .CARR_ON(CARR_ON)) u_carr (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .carr_on (carr_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_out <= 1'b0;
      led_n  <= 1'b1;
    end else begin
      ir_out <= burst & carr_on;
      led_n  <= ~active;
    end
  end
endmodule

// File: rtl/irppm_tx_chk.sv
module irppm_tx_chk
  import irppm_pkg::*;
#(
  parameter int SLOT_CLKS   = 252,
  parameter int FRAME_SLOTS = 193
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           key_valid,
  input logic                           key_held,
  input logic                           ir_out,
  input logic                           led_n,
  input seq_st_t                        st,
  input logic [$clog2(SLOT_CLKS)-1:0]   sc,
  input logic [$clog2(FRAME_SLOTS)-1:0] per
);
  localparam int SCW = $clog2(SLOT_CLKS);
  localparam int PW  = $clog2(FRAME_SLOTS);

  logic period_end;
  assign period_end = (st == ST_WAIT) && (sc == SCW'(SLOT_CLKS - 1)) && (per == PW'(FRAME_SLOTS - 1));

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!ir_out && led_n));

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && key_valid) |=> (st == ST_HDR));

  p_repeat_start_r6: assert property (@(posedge clk) disable iff (rst)
    (period_end && key_held) |=> (st == ST_HDR));

  p_release_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (period_end && !key_held) |=> (st == ST_IDLE));

  p_led_covers_ir_r8: assert property (@(posedge clk) disable iff (rst)
    ir_out |-> !led_n);

  p_no_carrier_in_space_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_WAIT || st == ST_GAP || st == ST_SPACE) |=> !ir_out);

  p_slot_bound_r9: assert property (@(posedge clk) disable iff (rst)
    sc < SCW'(SLOT_CLKS));

  p_busy_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_WAIT) |=> (st != ST_IDLE));
endmodule

bind irppm_tx irppm_tx_chk #(.SLOT_CLKS(SLOT_CLKS), .FRAME_SLOTS(FRAME_SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .key_valid (key_valid),
  .key_held  (key_held),
  .ir_out    (ir_out),
  .led_n     (led_n),
  .st        (st_w),
  .sc        (sc_w),
  .per       (per_w)
);

// File: tb/sim_irppm_tx.sv
`timescale 1ns/1ps
module sim_irppm_tx;
  localparam int SLOT  = 6;
  localparam int DIV   = 3;
  localparam int ON    = 1;
  localparam int FRAME = 193;
  localparam int NCAP  = 4 * FRAME;
  localparam int PER_SLOT_HI = SLOT * ON / DIV;

  // addr, inv, mask_lo, mask_hi, data, expected low byte, expected high byte
  localparam logic [55:0] VEC [4] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'hA5, 8'hFF, 8'h00, 8'h00, 8'h3C, 8'hA5, 8'hA5},
    {8'h12, 8'h0F, 8'h40, 8'h30, 8'hFF, 8'h52, 8'h92},
    {8'hF0, 8'h00, 8'h0F, 8'hFF, 8'h81, 8'hFF, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_valid = 1'b0;
  logic key_held = 1'b0;
  logic [7:0] addr_sw = '0, inv_sw = '0, mask_lo = '0, mask_hi = '0, data_code = '0;
  logic ir_out, led_n;

  int checks = 0;
  int errors = 0;
  int env  [NCAP];
  int ledc [NCAP];
  bit expb [NCAP];
  bit expl [NCAP];
  bit seen;

  always #4 clk = ~clk;

  irppm_tx #(.SLOT_CLKS(SLOT), .CARR_DIV(DIV), .CARR_ON(ON), .FRAME_SLOTS(FRAME)) u0 (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_held(key_held),
    .addr_sw(addr_sw), .inv_sw(inv_sw), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .data_code(data_code), .ir_out(ir_out), .led_n(led_n)
  );

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    for (int k = 0; k < NCAP; k++) begin expb[k] = 1'b0; expl[k] = 1'b0; end
  endtask

  task automatic add_full(input int base, input logic [31:0] w);
    int pos;
    for (int k = 0; k < 16; k++) expb[base + k] = 1'b1;
    pos = base + 24;
    for (int b = 0; b < 32; b++) begin
      expb[pos] = 1'b1;
      pos += w[b] ? 4 : 2;
    end
    expb[pos] = 1'b1;
    for (int k = base; k <= pos; k++) expl[k] = 1'b1;
  endtask

  task automatic add_rep(input int base);
    for (int k = 0; k < 16; k++) expb[base + k] = 1'b1;
    expb[base + 20] = 1'b1;
    for (int k = base; k <= base + 20; k++) expl[k] = 1'b1;
  endtask

  task automatic launch(input bit held);
    @(negedge clk);
    key_held = held;
    key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  // slot-aligned capture from the first carrier pulse of the frame
  task automatic capture(input int n, input int rel_slot, input int kv_slot);
    int t;
    int cnt, lc;
    t = 0;
    while (!ir_out && t < 100) begin @(negedge clk); t++; end
    seen = ir_out;
    for (int k = 0; k < n; k++) begin
      cnt = 0; lc = 0;
      for (int j = 0; j < SLOT; j++) begin
        if (ir_out) cnt++;
        if (!led_n) lc++;
        if (k == rel_slot && j == 0) key_held = 1'b0;
        key_valid = (k == kv_slot && j == 0);
        @(negedge clk);
      end
      env[k] = cnt; ledc[k] = lc;
    end
    key_valid = 1'b0;
  endtask

  task automatic cmp_env(input int n, input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int k = 0; k < n; k++)
      if (env[k] != (expb[k] ? PER_SLOT_HI : 0)) begin bad++; if (first < 0) first = k; end
    if (first < 0) first = 0;
    chk(seen && bad == 0, req, $sformatf("carrier count per slot, first bad slot %0d", first),
        env[first], expb[first] ? PER_SLOT_HI : 0);
  endtask

  task automatic cmp_led(input int n);
    int bad, first;
    bad = 0; first = -1;
    for (int k = 0; k < n; k++)
      if (ledc[k] != (expl[k] ? SLOT : 0)) begin bad++; if (first < 0) first = k; end
    if (first < 0) first = 0;
    chk(bad == 0, "R8", $sformatf("indicator low clocks, first bad slot %0d", first),
        ledc[first], expl[first] ? SLOT : 0);
  endtask

  function automatic logic [31:0] decode();
    logic [31:0] w;
    int pos, z;
    w = '0; pos = 24;
    for (int b = 0; b < 32; b++) begin
      z = 0; pos++;
      while (pos < NCAP && env[pos] == 0 && z < 5) begin z++; pos++; end
      w[b] = (z == 3);
    end
    return w;
  endfunction

  initial begin
    logic [31:0] w, rx;
    int hits;
    // reset state
    repeat (3) @(negedge clk);
    chk(ir_out == 1'b0, "R1", "ir_out in reset", ir_out, 0);
    chk(led_n == 1'b1, "R1", "led_n in reset", led_n, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // table of single full frames, key released
    for (int v = 0; v < 4; v++) begin
      addr_sw   = VEC[v][55:48];
      inv_sw    = VEC[v][47:40];
      mask_lo   = VEC[v][39:32];
      mask_hi   = VEC[v][31:24];
      data_code = VEC[v][23:16];
      w = {~VEC[v][23:16], VEC[v][23:16], VEC[v][7:0], VEC[v][15:8]};
      clear_exp();
      add_full(0, w);
      launch(1'b0);
      capture(2 * FRAME, -1, -1);
      cmp_env(2 * FRAME, "R2/R3/R7/R9");
      cmp_led(2 * FRAME);
      rx = decode();
      chk(rx[7:0] == VEC[v][15:8], "R4", "low address byte", rx[7:0], VEC[v][15:8]);
      chk(rx[15:8] == VEC[v][7:0], "R5", "high address byte", rx[15:8], VEC[v][7:0]);
      chk(rx[23:16] == VEC[v][23:16], "R3", "data byte", rx[23:16], VEC[v][23:16]);
      chk(rx[31:24] == ~VEC[v][23:16], "R3", "complement byte", rx[31:24], ~VEC[v][23:16]);
    end

    // held key: full frame, two repeats, release inside the second repeat
    addr_sw = 8'hA5; inv_sw = 8'hFF; mask_lo = '0; mask_hi = '0; data_code = 8'h3C;
    w = {8'hC3, 8'h3C, 8'hA5, 8'hA5};
    clear_exp();
    add_full(0, w);
    add_rep(FRAME);
    add_rep(2 * FRAME);
    launch(1'b1);
    capture(NCAP, 2 * FRAME + 4, -1);
    cmp_env(NCAP, "R6/R7");
    cmp_led(NCAP);

    // key_valid pulses while busy and while waiting are ignored
    clear_exp();
    add_full(0, w);
    launch(1'b0);
    capture(2 * FRAME, -1, 50);
    cmp_env(2 * FRAME, "R10");
    launch(1'b0);
    capture(2 * FRAME, -1, 180);
    cmp_env(2 * FRAME, "R10");

    // reset in the middle of a frame
    launch(1'b1);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(ir_out == 1'b0, "R1", "ir_out after mid-frame reset", ir_out, 0);
    chk(led_n == 1'b1, "R1", "led_n after mid-frame reset", led_n, 1);
    rst = 1'b0;
    hits = 0;
    for (int c = 0; c < FRAME * SLOT + 50; c++) begin
      if (ir_out || !led_n) hits++;
      @(negedge clk);
    end
    chk(hits == 0, "R1", "activity after mid-frame reset", hits, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule